// File: doc/BRIEF.md
# Coincident Edge Detector

This block watches two slow, asynchronous level signals and reports when both of them change within the same period of a faster sampling clock. Neither watched signal ever clocks a flip-flop: each is treated as data, passed through a two-flop synchronizer and compared against its own sample from the previous sampling cycle. A difference between the two samples is an edge. A mode input narrows the edge test to low-to-high changes only.

For each input the block gives a one-cycle edge strobe. It gives a coincidence pulse when both inputs show an edge in the same sample slot and two qualifier inputs are both high in that cycle. On every sampling edge a registered output loads a supplied value. On a qualified coincidence it loads the inverse of that value. A two-state latch machine (states `LATCH_EMPTY` and `LATCH_SET`) keeps a sticky record that a coincidence happened. Its transitions are `SET_ON_COIN` (`LATCH_EMPTY` to `LATCH_SET` when a qualified coincidence occurs) and `CLEAR_ON_REQ` (`LATCH_SET` to `LATCH_EMPTY` when clear is high and no coincidence occurs in that cycle). A saturating counter tallies the coincidences. The sampling clock must run at least twice as fast as the faster watched signal, and preferably much faster.

Top module: `coin_edge_det`

## Requirements
- R1: A level change on a watched input that is first captured at sampling edge N makes that input's edge strobe high after edge N+2. The strobe stays high for exactly one cycle.
- R2: With `mode_rise` = 0 (any-edge mode), both a 0-to-1 change and a 1-to-0 change on an input produce its edge strobe.
- R3: With `mode_rise` = 1 (rising-only mode), only a 0-to-1 change produces the strobe. A 1-to-0 change produces no strobe and no coincidence.
- R4: `coin_pulse` is high for one cycle exactly when both inputs give an edge in the same sample slot and `qual_x` and `qual_y` are both high in that cycle. If either qualifier is low, there is no pulse.
- R5: `tog_out` loads the inverse of `tog_in` in a cycle where a qualified coincidence is detected. In every other cycle it loads `tog_in` unchanged.
- R6: `coin_held` goes high together with the first `coin_pulse` and stays high until a cycle with `clr_held` high. It is low in the cycle after that clear.
- R7: When `clr_held` and a qualified coincidence fall in the same cycle, the coincidence wins and `coin_held` stays high.
- R8: `coin_count` increments by one on each qualified coincidence and saturates at 2^CNT_W-1.
- R9: Synchronous active-high `rst` drives every output to 0 (edge strobes, pulse, `tog_out`, `coin_held`, count) and clears the sample history, so no spurious edge follows reset while the inputs stay low.
- R10: The previous-sample registers reload on every sampling edge, so a single change yields one strobe and then the strobe returns to 0 while the input holds its new level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_smp | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| mon_a | input | 1 | First watched asynchronous signal |
| mon_b | input | 1 | Second watched asynchronous signal |
| mode_rise | input | 1 | 1: rising-only detection, 0: any change |
| qual_x | input | 1 | First coincidence qualifier |
| qual_y | input | 1 | Second coincidence qualifier |
| tog_in | input | 1 | Value loaded into `tog_out` (inverted on coincidence) |
| clr_held | input | 1 | Clears the sticky coincidence flag |
| edge_a | output | 1 | One-cycle edge strobe for `mon_a` |
| edge_b | output | 1 | One-cycle edge strobe for `mon_b` |
| coin_pulse | output | 1 | One-cycle qualified coincidence pulse |
| tog_out | output | 1 | Registered, conditionally inverted copy of `tog_in` |
| coin_held | output | 1 | Sticky coincidence flag |
| coin_count | output | CNT_W | Saturating coincidence count |

## Verification
The properties assume that the qualifiers, `tog_in`, `mode_rise` and `clr_held` are synchronous to the sampling clock. They also assume that each watched signal holds every level for at least two sampling cycles, which is the sampling-rate rule; the single-cycle strobe property depends on that. The stimulus changes every input half a period away from the active edge. It holds each watched level for at least three sampling cycles, which keeps the inputs inside both assumptions.

// File: rtl/cedp_pkg.sv
package cedp_pkg;

    // Edge test applied to each synchronized sample
    typedef enum logic {
        EDGE_ANY  = 1'b0,
        EDGE_RISE = 1'b1
    } edge_mode_e;

    // Sticky coincidence latch machine
    typedef enum logic {
        LATCH_EMPTY = 1'b0,
        LATCH_SET   = 1'b1
    } latch_state_e;

    localparam int unsigned NUM_MON = 2;

endpackage

// File: rtl/cedp_sync.sv
module cedp_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    localparam int unsigned LAST = STAGES - 1;

    logic [LAST:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain[0] <= din;
            for (int i = 1; i <= int'(LAST); i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign dout = chain[LAST];
endmodule

// File: rtl/cedp_edge.sv
module cedp_edge
    import cedp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       smp,
    input  edge_mode_e mode,
    output logic       det,
    output logic       strobe
);
    logic prev_q;

    // compare current synchronized sample with the one from last cycle
    always_comb begin
        unique case (mode)
            EDGE_ANY:  det = smp ^ prev_q;
            EDGE_RISE: det = smp & ~prev_q;
            default:   det = 1'b0;
        endcase
    end

    // history reloads every cycle regardless of outcome
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            strobe <= 1'b0;
        end else begin
            prev_q <= smp;
            strobe <= det;
        end
    end
endmodule

// File: rtl/cedp_latch_fsm.sv
module cedp_latch_fsm
    import cedp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic set_req,
    input  logic clr_req,
    output logic held
);
    latch_state_e state_q, state_d;

    // next-state and output decode
    always_comb begin
        state_d = state_q;
        held    = 1'b0;
        unique case (state_q)
            LATCH_EMPTY: begin
                if (set_req) state_d = LATCH_SET;          // SET_ON_COIN
            end
            LATCH_SET: begin
                held = 1'b1;
                if (clr_req && !set_req) state_d = LATCH_EMPTY; // CLEAR_ON_REQ
            end
            default: state_d = LATCH_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= LATCH_EMPTY;
        else     state_q <= state_d;
    end
endmodule

// File: rtl/cedp_counter.sv
module cedp_counter #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst)                          count <= '0;
        else if (inc && count != CNT_MAX) count <= count + 1'b1;
    end
endmodule

// File: rtl/coin_edge_det.sv
module coin_edge_det
    import cedp_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned CNT_W       = 8
) (
    input  logic             clk_smp,
    input  logic             rst,
    input  logic             mon_a,
    input  logic             mon_b,
    input  logic             mode_rise,
    input  logic             qual_x,
    input  logic             qual_y,
    input  logic             tog_in,
    input  logic             clr_held,
    output logic             edge_a,
    output logic             edge_b,
    output logic             coin_pulse,
    output logic             tog_out,
    output logic             coin_held,
    output logic [CNT_W-1:0] coin_count
);
    logic [NUM_MON-1:0] mon_raw;
    logic [NUM_MON-1:0] mon_smp;
    logic [NUM_MON-1:0] mon_det;
    logic [NUM_MON-1:0] mon_stb;
    logic               coin_hit;
    edge_mode_e         mode_sel;

    assign mon_raw  = {mon_b, mon_a};
    assign mode_sel = edge_mode_e'(mode_rise);

    for (genvar g = 0; g < NUM_MON; g++) begin : g_mon
        cedp_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk_smp),
            .rst  (rst),
            .din  (mon_raw[g]),
            .dout (mon_smp[g])
        );
        cedp_edge u_edge (
            .clk    (clk_smp),
            .rst    (rst),
            .smp    (mon_smp[g]),
            .mode   (mode_sel),
            .det    (mon_det[g]),
            .strobe (mon_stb[g])
        );
    end

    assign edge_a   = mon_stb[0];
    assign edge_b   = mon_stb[1];
    assign coin_hit = (&mon_det) & qual_x & qual_y;

    always_ff @(posedge clk_smp) begin
        if (rst) begin
            coin_pulse <= 1'b0;
            tog_out    <= 1'b0;
        end else begin
            coin_pulse <= coin_hit;
            tog_out    <= coin_hit ? ~tog_in : tog_in;
        end
    end

    cedp_latch_fsm u_latch (
        .clk     (clk_smp),
        .rst     (rst),
        .set_req (coin_hit),
        .clr_req (clr_held),
        .held    (coin_held)
    );

    cedp_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk_smp),
        .rst   (rst),
        .inc   (coin_hit),
        .count (coin_count)
    );
endmodule

// File: rtl/coin_edge_det_chk.sv
module coin_edge_det_chk #(
    parameter int unsigned CNT_W = 8
) (
    input logic             clk_smp,
    input logic             rst,
    input logic             qual_x,
    input logic             qual_y,
    input logic             tog_in,
    input logic             edge_a,
    input logic             edge_b,
    input logic             coin_pulse,
    input logic             tog_out,
    input logic             coin_held,
    input logic [CNT_W-1:0] coin_count
);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    p_single_strobe_r1: assert property (@(posedge clk_smp) disable iff (rst)
        edge_a |=> !edge_a);

    p_pulse_edges_r4: assert property (@(posedge clk_smp) disable iff (rst)
        coin_pulse |-> (edge_a && edge_b));

    p_pulse_quals_r4: assert property (@(posedge clk_smp) disable iff (rst)
        (coin_pulse && !$past(rst)) |-> $past(qual_x && qual_y));

    p_tog_follow_r5: assert property (@(posedge clk_smp) disable iff (rst)
        !$past(rst) |-> (tog_out == ($past(tog_in) ^ coin_pulse)));

    p_held_on_pulse_r6: assert property (@(posedge clk_smp) disable iff (rst)
        coin_pulse |-> coin_held);

    p_count_sat_r8: assert property (@(posedge clk_smp) disable iff (rst)
        (coin_count == CNT_TOP) |=> (coin_count == CNT_TOP));

    p_count_step_r8: assert property (@(posedge clk_smp) disable iff (rst)
        (!$past(rst) && coin_count != $past(coin_count)) |-> coin_pulse);

    always_comb begin
        if (!rst) a_outs_known_r9: assert (!$isunknown({coin_pulse, coin_held, coin_count}));
    end
endmodule

bind coin_edge_det coin_edge_det_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_smp    (clk_smp),
    .rst        (rst),
    .qual_x     (qual_x),
    .qual_y     (qual_y),
    .tog_in     (tog_in),
    .edge_a     (edge_a),
    .edge_b     (edge_b),
    .coin_pulse (coin_pulse),
    .tog_out    (tog_out),
    .coin_held  (coin_held),
    .coin_count (coin_count)
);

// File: tb/test_coin_edge_det.sv
`timescale 1ns/1ps
module test_coin_edge_det;
    localparam int CNT_W = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mon_a = 0, mon_b = 0, mode_rise = 0, qual_x = 0, qual_y = 0;
    logic tog_in = 0, clr_held = 0;
    logic edge_a, edge_b, coin_pulse, tog_out, coin_held;
    logic [CNT_W-1:0] coin_count;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    coin_edge_det #(.SYNC_STAGES(2), .CNT_W(CNT_W)) i_coin_edge_det (
        .clk_smp(clk), .rst(rst), .mon_a(mon_a), .mon_b(mon_b),
        .mode_rise(mode_rise), .qual_x(qual_x), .qual_y(qual_y),
        .tog_in(tog_in), .clr_held(clr_held), .edge_a(edge_a), .edge_b(edge_b),
        .coin_pulse(coin_pulse), .tog_out(tog_out), .coin_held(coin_held),
        .coin_count(coin_count)
    );

    // {a, b, mode, qx, qy, tog_in | exp edge_a, edge_b, coin, tog_out}
    localparam logic [9:0] VEC [10] = '{
        10'b100_110_1000,  // a rises alone
        10'b110_111_0101,  // b rises alone, a holds
        10'b000_110_1111,  // both fall, any-edge: coincidence
        10'b111_111_1110,  // both rise, rising mode: coincidence
        10'b001_110_0000,  // both fall, rising mode: nothing
        10'b110_101_1101,  // both rise, qual_y low
        10'b000_010_1100,  // both fall, qual_x low
        10'b101_111_1001,  // a rises alone, rising mode
        10'b011_110_0100,  // a falls (ignored), b rises
        10'b100_110_1111   // a rises, b falls, any-edge: coincidence
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_reset(input string req);
        check(req, {edge_a, edge_b, coin_pulse, tog_out, coin_held}, 0);
        check(req, coin_count, 0);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        step(3);
        check_reset("R9 reset state");
        rst = 0;
        step(4);
        check_reset("R9 no spurious edge after reset");

        // R1 latency: visible after the third falling edge, not the second
        mon_a = 1;
        step(2);
        check("R1 strobe not early", edge_a, 0);
        step(1);
        check("R1 strobe latency", edge_a, 1);
        step(1);
        check("R10 strobe single cycle", edge_a, 0);
        mon_a = 0;
        step(4);
        rst = 1; step(2); rst = 0;

        for (int i = 0; i < 10; i++) begin
            {mon_a, mon_b, mode_rise, qual_x, qual_y, tog_in} = VEC[i][9:4];
            step(3);
            check("R1 R2 R3 edge_a", edge_a, VEC[i][3]);
            check("R1 R2 R3 edge_b", edge_b, VEC[i][2]);
            check("R4 coin_pulse", coin_pulse, VEC[i][1]);
            check("R5 tog_out", tog_out, VEC[i][0]);
        end

        step(1);
        check("R10 strobes return low", {edge_a, edge_b, coin_pulse}, 0);
        check("R8 count after table", coin_count, 3);
        check("R6 held after coincidences", coin_held, 1);

        clr_held = 1; step(1); clr_held = 0;
        check("R6 held cleared", coin_held, 0);
        check("R8 count kept on clear", coin_count, 3);

        // R7: clear in the same cycle as a coincidence
        mode_rise = 0; qual_x = 1; qual_y = 1;
        mon_a = 0; mon_b = 1;
        step(2);
        clr_held = 1;
        step(1);
        clr_held = 0;
        check("R7 coincidence beats clear", coin_held, 1);
        check("R7 pulse present", coin_pulse, 1);
        check("R8 count step", coin_count, 4);

        for (int k = 0; k < 5; k++) begin
            mon_a = ~mon_a; mon_b = ~mon_b;
            step(4);
        end
        check("R8 count saturates", coin_count, 7);

        rst = 1; step(2);
        check_reset("R9 reset mid-run");
        rst = 0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule